// File: doc/BRIEF.md
# Mailbox Command Sequencer

This block issues one command at a time to a power-management controller that is reached through three memory-mapped mailbox words: a response word, an argument word and a command word. A client hands over a command number and a 32-bit argument on a valid/ready handshake. The sequencer then drives a plain single-cycle register port. It first polls the response word until the previous exchange has finished, and a zero there means busy. It then clears the response word, stores the argument and writes the command number, and that last write starts the controller. It polls the response word again, and finally reads the argument word back, because the controller leaves its answer there.

Polling is paced by a programmable interval in microseconds, which the `CYC_PER_US` parameter turns into clock cycles. A programmable retry limit N allows N+1 reads per polling phase. A host would normally program an interval of 10 us and a limit of 200000. The client receives a one-cycle completion pulse with the read-back word, the controller's status byte (0x01 success, 0xFF failure, 0xFE unknown command, 0xFD prerequisite missing, 0xFC busy, so the command should be sent again) and three flags: warning, abort and timeout.

The FSM has these states. `ST_IDLE` takes a request and goes to `ST_PRE_RD`. `ST_PRE_RD` reads the response word. It moves to `ST_CLR` when the word is non-zero, to `ST_DONE` (abort) when it is busy and no retries are left, and to `ST_PRE_WAIT` otherwise. `ST_PRE_WAIT` returns to `ST_PRE_RD` when the timer expires. After that the FSM steps through `ST_CLR`, `ST_WR_ARG`, `ST_WR_ID` and `ST_POST_RD`. `ST_POST_RD` goes to `ST_RD_RES` when the response is non-zero or the retries are used up, and to `ST_POST_WAIT` otherwise. `ST_POST_WAIT` returns to `ST_POST_RD` when the timer expires. The FSM then takes `ST_RD_RES` to `ST_DONE` and `ST_DONE` to `ST_IDLE`.

Top module: `mbox_cmd_seq`

## Requirements
- R1: After reset, `req_ready` is 1, `rsp_valid` is 0 and neither `bus_rd` nor `bus_wr` is asserted.
- R2: Only one request is in flight. `req_ready` is 0 from the cycle after acceptance up to and including the `rsp_valid` cycle.
- R3: Before issuing, the response address is read until a non-zero word is seen. The all-zero word means busy. With `cfg_max_retry` = N there are at most N+1 such reads.
- R4: If all N+1 pre-issue reads return zero, no bus write occurs. The completion then has `rsp_abort`=1, `rsp_data`=0 and `rsp_code`=0.
- R5: A non-zero pre-issue response other than 0x01 sets `rsp_warn`=1 and the exchange still proceeds. A pre-issue value of 0x01 leaves `rsp_warn`=0.
- R6: Issuing is exactly three writes in consecutive cycles: 0 to the response address, then the argument to the argument address, then the zero-extended command number to the command address.
- R7: After the command write, the response address is polled again with the same limit (at most N+1 reads). `rsp_code` is bits 7:0 of the first non-zero word.
- R8: If all N+1 post-issue reads return zero, `rsp_timeout`=1 and `rsp_code`=0, and the argument address is still read back.
- R9: Every exchange that is not aborted ends with one read of the argument address, and `rsp_data` equals the word read.
- R10: Within one polling phase, consecutive response reads start max(1, `cfg_delay_us`*`CYC_PER_US`)+1 cycles apart.
- R11: `bus_rd` and `bus_wr` are never asserted in the same cycle.
- R12: `rsp_valid` is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_delay_us | input | DLY_W | Polling interval in microseconds |
| cfg_max_retry | input | RTY_W | Retries per polling phase (N gives N+1 reads) |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle, request accepted when valid |
| req_msg | input | ID_W | Command number |
| req_arg | input | DATA_W | Command argument |
| rsp_valid | output | 1 | Completion pulse |
| rsp_data | output | DATA_W | Word read back from the argument address |
| rsp_code | output | 8 | Controller status byte, 0 on abort or timeout |
| rsp_warn | output | 1 | Pre-issue response was non-zero but not success |
| rsp_abort | output | 1 | Controller stayed busy before issue, nothing written |
| rsp_timeout | output | 1 | No response after the command write |
| bus_rd | output | 1 | Register read strobe |
| bus_wr | output | 1 | Register write strobe |
| bus_addr | output | ADDR_W | Register address |
| bus_wdata | output | DATA_W | Write data |
| bus_rdata | input | DATA_W | Read data, valid in the cycle of `bus_rd` |

## Verification
The hardest case to reach from the ports is the boundary of the retry limit. The controller has to stay busy for exactly N reads in one case and for N+1 reads in the other, in either polling phase, while the pacing between reads is also measured. The bench's mailbox model counts the response reads separately in each phase and returns zero until a chosen count is reached. This lets it place the first non-zero answer on the last allowed read or one read past it. The sweep covers several retry limits, intervals and status codes.

// File: rtl/mbox_seq_pkg.sv
package mbox_seq_pkg;

    localparam int CODE_W = 8;

    localparam logic [CODE_W-1:0] RESP_OK        = 8'h01;
    localparam logic [CODE_W-1:0] RESP_FAILED    = 8'hFF;
    localparam logic [CODE_W-1:0] RESP_UNKNOWN   = 8'hFE;
    localparam logic [CODE_W-1:0] RESP_PREREQ    = 8'hFD;
    localparam logic [CODE_W-1:0] RESP_RETRY     = 8'hFC;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_PRE_RD,
        ST_PRE_WAIT,
        ST_CLR,
        ST_WR_ARG,
        ST_WR_ID,
        ST_POST_RD,
        ST_POST_WAIT,
        ST_RD_RES,
        ST_DONE
    } seq_state_t;

endpackage

// File: rtl/mbox_wait_timer.sv
module mbox_wait_timer #(
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             run,
    input  logic [CNT_W-1:0] total,
    output logic             expire
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (start) begin
            cnt_q <= total;
        end else if (run && cnt_q > CNT_W'(1)) begin
            cnt_q <= cnt_q - CNT_W'(1);
        end
    end

    assign expire = run && (cnt_q <= CNT_W'(1));

    // R10: a load never coincides with a running wait
    a_r10_start_not_running: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !run);

    // R10: while running, the count only falls
    a_r10_count_falls: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !start && cnt_q > CNT_W'(1)) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));

endmodule

// File: rtl/mbox_retry_ctr.sv
module mbox_retry_ctr #(
    parameter int RTY_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [RTY_W-1:0] limit,
    input  logic             dec,
    output logic             exhausted
);

    logic [RTY_W-1:0] left_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            left_q <= '0;
        end else if (load) begin
            left_q <= limit;
        end else if (dec) begin
            left_q <= left_q - RTY_W'(1);
        end
    end

    assign exhausted = (left_q == '0);

    // R3: a retry is never taken when none remain
    a_r3_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        dec |-> (left_q != '0));

    // R7: load and decrement never collide
    a_r7_load_dec_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(load && dec));

endmodule

// File: rtl/mbox_cmd_seq.sv
module mbox_cmd_seq
    import mbox_seq_pkg::*;
#(
    parameter int          ADDR_W     = 16,
    parameter int          DATA_W     = 32,
    parameter int          ID_W       = 8,
    parameter int          DLY_W      = 16,
    parameter int          RTY_W      = 20,
    parameter int          CYC_PER_US = 100,
    parameter logic [15:0] RESP_ADDR  = 16'h016C,
    parameter logic [15:0] PARAM_ADDR = 16'h014C,
    parameter logic [15:0] MSG_ADDR   = 16'h010C
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DLY_W-1:0]  cfg_delay_us,
    input  logic [RTY_W-1:0]  cfg_max_retry,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ID_W-1:0]   req_msg,
    input  logic [DATA_W-1:0] req_arg,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_data,
    output logic [7:0]        rsp_code,
    output logic              rsp_warn,
    output logic              rsp_abort,
    output logic              rsp_timeout,
    output logic              bus_rd,
    output logic              bus_wr,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic [DATA_W-1:0] bus_rdata
);

    localparam int TOT_W = DLY_W + $clog2(CYC_PER_US + 1);
    localparam logic [ADDR_W-1:0] A_RESP  = ADDR_W'(RESP_ADDR);
    localparam logic [ADDR_W-1:0] A_PARAM = ADDR_W'(PARAM_ADDR);
    localparam logic [ADDR_W-1:0] A_MSG   = ADDR_W'(MSG_ADDR);

    seq_state_t state_q, state_d;

    logic [ID_W-1:0]   msg_q;
    logic [DATA_W-1:0] arg_q;
    logic [DATA_W-1:0] data_q;
    logic [7:0]        code_q;
    logic              warn_q, abort_q, timeout_q;

    logic              resp_busy;
    logic              is_poll;
    logic              exhausted;
    logic              retry_load, retry_dec;
    logic              tmr_start, tmr_run, tmr_expire;
    logic [TOT_W-1:0]  wait_cycles;

    assign resp_busy   = (bus_rdata == '0);
    assign is_poll     = (state_q == ST_PRE_RD) || (state_q == ST_POST_RD);
    assign wait_cycles = TOT_W'(cfg_delay_us) * TOT_W'(CYC_PER_US);
    assign retry_load  = ((state_q == ST_IDLE) && req_valid) || (state_q == ST_WR_ID);
    assign retry_dec   = is_poll && resp_busy && !exhausted;
    assign tmr_start   = retry_dec;
    assign tmr_run     = (state_q == ST_PRE_WAIT) || (state_q == ST_POST_WAIT);

    mbox_retry_ctr #(.RTY_W(RTY_W)) u_retry (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (retry_load),
        .limit     (cfg_max_retry),
        .dec       (retry_dec),
        .exhausted (exhausted)
    );

    mbox_wait_timer #(.CNT_W(TOT_W)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (tmr_start),
        .run    (tmr_run),
        .total  (wait_cycles),
        .expire (tmr_expire)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:      if (req_valid) state_d = ST_PRE_RD;
            ST_PRE_RD: begin
                if (!resp_busy)     state_d = ST_CLR;
                else if (exhausted) state_d = ST_DONE;
                else                state_d = ST_PRE_WAIT;
            end
            ST_PRE_WAIT:  if (tmr_expire) state_d = ST_PRE_RD;
            ST_CLR:       state_d = ST_WR_ARG;
            ST_WR_ARG:    state_d = ST_WR_ID;
            ST_WR_ID:     state_d = ST_POST_RD;
            ST_POST_RD: begin
                if (!resp_busy || exhausted) state_d = ST_RD_RES;
                else                         state_d = ST_POST_WAIT;
            end
            ST_POST_WAIT: if (tmr_expire) state_d = ST_POST_RD;
            ST_RD_RES:    state_d = ST_DONE;
            ST_DONE:      state_d = ST_IDLE;
            default:      state_d = ST_IDLE;
        endcase
    end

    // captured request and result fields
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            msg_q     <= '0;
            arg_q     <= '0;
            data_q    <= '0;
            code_q    <= '0;
            warn_q    <= 1'b0;
            abort_q   <= 1'b0;
            timeout_q <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (req_valid) begin
                    msg_q     <= req_msg;
                    arg_q     <= req_arg;
                    data_q    <= '0;
                    code_q    <= '0;
                    warn_q    <= 1'b0;
                    abort_q   <= 1'b0;
                    timeout_q <= 1'b0;
                end
                ST_PRE_RD: begin
                    if (!resp_busy)     warn_q  <= (bus_rdata[7:0] != RESP_OK) || (bus_rdata[DATA_W-1:8] != '0);
                    else if (exhausted) abort_q <= 1'b1;
                end
                ST_POST_RD: begin
                    if (!resp_busy)     code_q    <= bus_rdata[7:0];
                    else if (exhausted) timeout_q <= 1'b1;
                end
                ST_RD_RES: data_q <= bus_rdata;
                default: ;
            endcase
        end
    end

    // outputs decoded from state
    always_comb begin
        req_ready = 1'b0;
        rsp_valid = 1'b0;
        bus_rd    = 1'b0;
        bus_wr    = 1'b0;
        bus_addr  = '0;
        bus_wdata = '0;
        unique case (state_q)
            ST_IDLE:    req_ready = 1'b1;
            ST_PRE_RD, ST_POST_RD: begin
                bus_rd   = 1'b1;
                bus_addr = A_RESP;
            end
            ST_CLR: begin
                bus_wr   = 1'b1;
                bus_addr = A_RESP;
            end
            ST_WR_ARG: begin
                bus_wr    = 1'b1;
                bus_addr  = A_PARAM;
                bus_wdata = arg_q;
            end
            ST_WR_ID: begin
                bus_wr    = 1'b1;
                bus_addr  = A_MSG;
                bus_wdata = DATA_W'(msg_q);
            end
            ST_RD_RES: begin
                bus_rd   = 1'b1;
                bus_addr = A_PARAM;
            end
            ST_DONE:    rsp_valid = 1'b1;
            default: ;
        endcase
    end

    assign rsp_data    = data_q;
    assign rsp_code    = code_q;
    assign rsp_warn    = warn_q;
    assign rsp_abort   = abort_q;
    assign rsp_timeout = timeout_q;

    a_r11_single_access: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_rd && bus_wr));

    a_r6_clear_then_arg: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == A_RESP) |=> (bus_wr && bus_addr == A_PARAM));

    a_r6_arg_then_id: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == A_PARAM) |=> (bus_wr && bus_addr == A_MSG));

    a_r6_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == A_RESP) |-> (bus_wdata == '0));

    a_r12_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    a_r2_accept_drops_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    a_r2_ready_low_at_done: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !req_ready);

    a_r4_abort_clean: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_abort) |-> (rsp_data == '0 && rsp_code == '0 && !rsp_timeout));

    a_r8_timeout_code: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_timeout) |-> (rsp_code == '0));

endmodule

// File: tb/mbox_cmd_seq_bench.sv
module mbox_cmd_seq_bench;

    localparam int ADDR_W = 16;
    localparam int DATA_W = 32;
    localparam int ID_W   = 8;
    localparam int DLY_W  = 16;
    localparam int RTY_W  = 20;
    localparam int CPU    = 3;
    localparam logic [15:0] A_RESP  = 16'h0020;
    localparam logic [15:0] A_PARAM = 16'h0024;
    localparam logic [15:0] A_MSG   = 16'h0028;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic [DLY_W-1:0]  cfg_delay_us = '0;
    logic [RTY_W-1:0]  cfg_max_retry = '0;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic [ID_W-1:0]   req_msg = '0;
    logic [DATA_W-1:0] req_arg = '0;
    logic              rsp_valid;
    logic [DATA_W-1:0] rsp_data;
    logic [7:0]        rsp_code;
    logic              rsp_warn, rsp_abort, rsp_timeout;
    logic              bus_rd, bus_wr;
    logic [ADDR_W-1:0] bus_addr;
    logic [DATA_W-1:0] bus_wdata;
    logic [DATA_W-1:0] bus_rdata;

    mbox_cmd_seq #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ID_W(ID_W), .DLY_W(DLY_W),
        .RTY_W(RTY_W), .CYC_PER_US(CPU),
        .RESP_ADDR(A_RESP), .PARAM_ADDR(A_PARAM), .MSG_ADDR(A_MSG)
    ) u_mbox_cmd_seq (
        .clk(clk), .rst_n(rst_n), .cfg_delay_us(cfg_delay_us), .cfg_max_retry(cfg_max_retry),
        .req_valid(req_valid), .req_ready(req_ready), .req_msg(req_msg), .req_arg(req_arg),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_code(rsp_code), .rsp_warn(rsp_warn),
        .rsp_abort(rsp_abort), .rsp_timeout(rsp_timeout), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
    );

    // mailbox model configuration (driven by the stimulus only)
    int          m_pre_busy = 0, m_post_busy = 0, exp_gap = 2;
    logic [7:0]  m_pre_code = 8'h01, m_post_code = 8'h01;
    logic [31:0] m_result = '0;
    logic        clear_req = 1'b0;

    // mailbox model state (driven by the monitor only)
    int          phase, pre_seen, post_seen, wr_n, gap_bad, ready_bad, other_bad;
    int          cyc, last_rd;
    logic        in_txn;
    logic [31:0] resp_reg, param_reg;
    logic [15:0] wr_addr [4];
    logic [31:0] wr_data [4];
    int          wr_cyc  [4];

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == A_RESP) begin
            if (phase == 0)      bus_rdata = (pre_seen < m_pre_busy) ? 32'h0 : {24'h0, m_pre_code};
            else if (phase == 2) bus_rdata = (post_seen < m_post_busy) ? 32'h0 : {24'h0, m_post_code};
            else                 bus_rdata = resp_reg;
        end else if (bus_addr == A_PARAM) begin
            bus_rdata = (phase == 2 && post_seen > m_post_busy) ? m_result : param_reg;
        end
    end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (clear_req) begin
            phase <= 0; pre_seen <= 0; post_seen <= 0; wr_n <= 0;
            gap_bad <= 0; ready_bad <= 0; other_bad <= 0; last_rd <= -1;
            resp_reg <= '0; param_reg <= '0; in_txn <= 1'b0;
        end else begin
            if (req_valid && req_ready) in_txn <= 1'b1;
            else if (rsp_valid)         in_txn <= 1'b0;
            if (in_txn && req_ready) ready_bad <= ready_bad + 1;
            if (bus_rd && bus_addr == A_RESP) begin
                if (last_rd >= 0 && (cyc - last_rd) != exp_gap) gap_bad <= gap_bad + 1;
                last_rd <= cyc;
                if (phase == 0) pre_seen <= pre_seen + 1;
                else if (phase == 2) post_seen <= post_seen + 1;
                else other_bad <= other_bad + 1;
            end
            if (bus_wr) begin
                if (wr_n < 4) begin
                    wr_addr[wr_n] <= bus_addr; wr_data[wr_n] <= bus_wdata; wr_cyc[wr_n] <= cyc;
                end
                wr_n <= wr_n + 1;
                last_rd <= -1;
                if (bus_addr == A_RESP) begin resp_reg <= bus_wdata; if (phase == 0) phase <= 1; end
                if (bus_addr == A_PARAM) param_reg <= bus_wdata;
                if (bus_addr == A_MSG) phase <= 2;
            end
        end
    end

    int errors = 0, checks = 0;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic run_txn(input int n, input int d, input logic [7:0] msg, input logic [31:0] arg,
                           input int pb, input logic [7:0] pc, input int qb,
                           input logic [7:0] qc, input logic [31:0] res);
        int w, pre_exp, post_exp;
        bit ab, to;
        @(negedge clk);
        cfg_max_retry = RTY_W'(n);
        cfg_delay_us  = DLY_W'(d);
        w = (d * CPU < 1) ? 1 : d * CPU;
        exp_gap = w + 1;
        m_pre_busy = pb; m_pre_code = pc; m_post_busy = qb; m_post_code = qc; m_result = res;
        clear_req = 1'b1;
        @(negedge clk);
        clear_req = 1'b0;
        req_msg = msg; req_arg = arg; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        while (!rsp_valid) @(negedge clk);
        ab = (pb > n);
        to = !ab && (qb > n);
        pre_exp  = ab ? n + 1 : pb + 1;
        post_exp = ab ? 0 : (to ? n + 1 : qb + 1);
        chk(pre_seen == pre_exp, "R3 pre-issue read count", pre_seen, pre_exp);
        chk(rsp_abort == ab, "R4 abort flag", rsp_abort, ab);
        chk(gap_bad == 0, "R10 read spacing", gap_bad, 0);
        chk(ready_bad == 0 && other_bad == 0, "R2 ready held low", ready_bad + other_bad, 0);
        chk(post_seen == post_exp, "R7 post-issue read count", post_seen, post_exp);
        if (ab) begin
            chk(wr_n == 0, "R4 no writes on abort", wr_n, 0);
            chk(rsp_data == 0 && rsp_code == 0, "R4 abort result", rsp_data, 0);
        end else begin
            chk(rsp_warn == (pc != 8'h01), "R5 warning flag", rsp_warn, pc != 8'h01);
            chk(wr_n == 3, "R6 write count", wr_n, 3);
            chk(wr_addr[0] == A_RESP && wr_data[0] == 0, "R6 clear first", wr_data[0], 0);
            chk(wr_addr[1] == A_PARAM && wr_data[1] == arg, "R6 argument second", wr_data[1], arg);
            chk(wr_addr[2] == A_MSG && wr_data[2] == {24'h0, msg}, "R6 command last", wr_data[2], msg);
            chk(wr_cyc[1] == wr_cyc[0] + 1 && wr_cyc[2] == wr_cyc[1] + 1, "R6 consecutive writes",
                wr_cyc[2] - wr_cyc[0], 2);
            chk(rsp_timeout == to, "R8 timeout flag", rsp_timeout, to);
            chk(rsp_code == (to ? 8'h00 : qc), "R7 status code", rsp_code, to ? 8'h00 : qc);
            chk(rsp_data == (to ? arg : res), "R9 read-back data", rsp_data, to ? arg : res);
        end
        @(negedge clk);
        chk(!rsp_valid && req_ready, "R12 single pulse then ready", rsp_valid, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(req_ready == 1'b1, "R1 ready in reset", req_ready, 1);
        chk(!bus_rd && !bus_wr && !rsp_valid, "R1 quiet in reset", {bus_rd, bus_wr, rsp_valid}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready && !bus_rd && !bus_wr && !rsp_valid, "R1 idle after reset", req_ready, 1);
        for (int n = 0; n <= 3; n += 3) begin
            for (int d = 0; d <= 2; d++) begin
                run_txn(n, d, 8'h04, 32'h0000_1234 + n + d, 0, 8'h01, n, 8'h01, 32'hA500_0000 + d);
                run_txn(n, d, 8'h06, 32'hDEAD_0000 + d, n, 8'hFC, 0, 8'hFE, 32'h0000_0077);
                run_txn(n, d, 8'h07, 32'h0000_00AA, n + 1, 8'h01, 0, 8'h01, 32'h1);
                run_txn(n, d, 8'h15, 32'h0000_0001, 0, 8'hFF, n + 1, 8'h01, 32'h5555_5555);
            end
        end
        for (int c = 0; c < 4; c++) begin
            run_txn(1, 1, 8'h0B, 32'h10 + c, 1, 8'hFC + 8'(c), 1, 8'hFC + 8'(c), 32'h200 + c);
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule